// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer with Hold Chopping

This block produces the four coil phase signals (A, B, C, D) that a stepper motor power stage needs. It steps through one of three energising patterns: single-phase (wave), two-phase (full step) or an alternating mix of the two (half step). It moves one state per step unit, where a step unit is a one-cycle clock-enable pulse from an external divider, gated by a step-enable input. A direction input picks forward or reverse order. The same phase signals suit unipolar and bipolar power stages; only the external power circuit differs.

When the stop input is high, stepping freezes. The one or two phases energised at that moment stay selected, but they are chopped by an internal 8-bit PWM with a programmable period and duty. This keeps holding torque while limiting average coil current. When stop falls, the phases return to a constant level and stepping resumes from the held state.

Top module: `stepper_phase_ctrl`

## Requirements
- R1: After reset the sequence is at state 0 in wave mode, and with stop low phase_out reads 4'b0001. Bit 0 is phase A, bit 1 is B, bit 2 is C and bit 3 is D.
- R2: Wave mode (mode code 0; code 3 behaves the same) steps forward through A, B, C, D, which is 0001, 0010, 0100, 1000, and then wraps.
- R3: Full-step mode (mode code 1) steps forward through AB, BC, CD, DA, which is 0011, 0110, 1100, 1001, and then wraps.
- R4: Half-step mode (mode code 2) steps forward through an 8-state cycle: 0001, 0011, 0010, 0110, 0100, 1100, 1000, 1001.
- R5: With dir high, each step moves one state backward through the same cycle, wrapping from state 0 to the last state.
- R6: The state advances by exactly one at a clock edge only when tick and step_en are both high and stop is low. Otherwise the phases are unchanged.
- R7: At the first clock edge where the mode input differs from the mode in use, the new mode is adopted and the sequence returns to state 0. No step is taken at that edge.
- R8: While stop is high the state is frozen, even when steps are requested. The phases shown are the frozen pattern ANDed with the hold PWM output.
- R9: The hold PWM counter is 0 while stop is low. While stop is high it counts up by one each clock and returns to 0 on the clock after it reaches or exceeds pwm_period. The PWM output is high while the counter is below pwm_duty.
- R10: While stop is high with pwm_duty equal to 0, all four phases are low.
- R11: When stop falls, the frozen pattern is shown again at a constant level, and stepping continues from the frozen state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle step time-unit pulse from an external divider |
| step_en | input | 1 | Allows stepping on tick |
| dir | input | 1 | 0 = forward order, 1 = reverse order |
| stop | input | 1 | Freezes stepping and chops the held phases |
| mode | input | 2 | 0 = wave, 1 = full step, 2 = half step, 3 = wave |
| pwm_period | input | 8 | Hold PWM counter wrap value |
| pwm_duty | input | 8 | Hold PWM on-count |
| phase_out | output | 4 | Phase drive, bit 0 = A through bit 3 = D |

## Verification
Sequence state, mode and PWM counter each change one clock edge after the input that causes them, so a step, a mode resync or a counter move shows on phase_out right after that edge. The stop and duty inputs reach phase_out combinationally, in the same cycle. The bench's driver applies each cycle's inputs on the falling edge and queues the output its own model predicts for the state after the next rising edge. A monitor samples 2 ns after that rising edge, while those inputs still hold, and pops and compares one expected item per cycle. Counter wrap, duty 0, reverse wrap and resync during hold each land in predicted cycles.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int NPH   = 4;
  localparam int IDX_W = 3;

  typedef enum logic [1:0] {
    MODE_WAVE = 2'd0,
    MODE_FULL = 2'd1,
    MODE_HALF = 2'd2,
    MODE_ALT  = 2'd3
  } step_mode_e;

  // number of states in one electrical cycle
  function automatic logic [IDX_W:0] seq_len(step_mode_e m);
    return (m == MODE_HALF) ? 4'd8 : 4'd4;
  endfunction

  // neighbour index in the cycle, wrapping both ways
  function automatic logic [IDX_W-1:0] step_index(logic [IDX_W-1:0] idx,
                                                  step_mode_e m, logic rev);
    logic [IDX_W:0] len;
    logic [IDX_W:0] wide;
    len  = seq_len(m);
    wide = {1'b0, idx};
    if (rev) wide = (wide == '0) ? len - 4'd1 : wide - 4'd1;
    else     wide = (wide == len - 4'd1) ? '0 : wide + 4'd1;
    return wide[IDX_W-1:0];
  endfunction

  function automatic logic [NPH-1:0] rotl4(logic [NPH-1:0] v, logic [1:0] n);
    logic [2*NPH-1:0] d;
    d = {v, v} << n;
    return d[2*NPH-1:NPH];
  endfunction

  // phase pattern for a state: bit0 = A .. bit3 = D
  function automatic logic [NPH-1:0] phase_pattern(step_mode_e m,
                                                   logic [IDX_W-1:0] idx);
    case (m)
      MODE_FULL: return rotl4(4'b0011, idx[1:0]);
      MODE_HALF: return idx[0] ? rotl4(4'b0011, idx[2:1])
                               : rotl4(4'b0001, idx[2:1]);
      default:   return rotl4(4'b0001, idx[1:0]);
    endcase
  endfunction
endpackage

// File: rtl/stp_sequencer.sv
module stp_sequencer
  import stp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             stop,
  input  logic             dir,
  input  step_mode_e       mode,
  output logic [IDX_W-1:0] idx,
  output step_mode_e       mode_q
);
  logic resync;
  logic do_step;

  assign resync  = (mode != mode_q);
  assign do_step = adv && !stop && !resync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      mode_q <= MODE_WAVE;
    end else begin
      mode_q <= mode;
      if (resync)       idx <= '0;
      else if (do_step) idx <= step_index(idx, mode_q, dir);
    end
  end

  p_resync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (idx == '0));
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !resync) |=> $stable(idx));
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !resync) |=> $stable(idx));
  p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_HALF) |-> (idx < 3'd4));
endmodule

// File: rtl/stp_hold_pwm.sv
module stp_hold_pwm #(
  parameter int PWM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [PWM_W-1:0] period,
  input  logic [PWM_W-1:0] duty,
  output logic             gate
);
  logic [PWM_W-1:0] cnt;
  logic             wrap;

  assign wrap = hold && (cnt >= period);
  assign gate = (cnt < duty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!hold)  cnt <= '0;
    else if (wrap)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (cnt == '0));
  p_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wrap) |=> (cnt == $past(cnt) + 1'b1));
  p_duty0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |-> !gate);
endmodule

// File: rtl/stp_phase_map.sv
module stp_phase_map
  import stp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  step_mode_e       mode_q,
  input  logic [IDX_W-1:0] idx,
  input  logic             hold,
  input  logic             gate,
  output logic [NPH-1:0]   phase
);
  logic [NPH-1:0] pattern;

  assign pattern = phase_pattern(mode_q, idx);
  assign phase   = (hold && !gate) ? '0 : pattern;

  p_wave_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && (mode_q == MODE_WAVE)) |-> ($countones(phase) == 1));
  p_full_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && (mode_q == MODE_FULL)) |-> ($countones(phase) == 2));
  p_hold_sub_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> ((phase & ~pattern) == '0));
endmodule

// File: rtl/stepper_phase_ctrl.sv
module stepper_phase_ctrl
  import stp_pkg::*;
#(
  parameter int PWM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             step_en,
  input  logic             dir,
  input  logic             stop,
  input  logic [1:0]       mode,
  input  logic [PWM_W-1:0] pwm_period,
  input  logic [PWM_W-1:0] pwm_duty,
  output logic [NPH-1:0]   phase_out
);
  logic             adv;
  logic [IDX_W-1:0] idx;
  step_mode_e       mode_q;
  logic             gate;

  assign adv = tick && step_en;

  stp_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .adv(adv), .stop(stop), .dir(dir),
    .mode(step_mode_e'(mode)), .idx(idx), .mode_q(mode_q)
  );

  stp_hold_pwm #(.PWM_W(PWM_W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .hold(stop), .period(pwm_period),
    .duty(pwm_duty), .gate(gate)
  );

  stp_phase_map u_map (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .idx(idx), .hold(stop),
    .gate(gate), .phase(phase_out)
  );
endmodule

// File: tb/stepper_phase_ctrl_test.sv
module stepper_phase_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, step_en = 1'b0, dir = 1'b0, stop = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] pwm_period = 8'd0, pwm_duty = 8'd0;
  logic [3:0] phase_out;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  // bench model state
  int m_idx = 0, m_mode = 0, m_cnt = 0;

  stepper_phase_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step_en(step_en), .dir(dir),
    .stop(stop), .mode(mode), .pwm_period(pwm_period), .pwm_duty(pwm_duty),
    .phase_out(phase_out)
  );

  always #5 clk = ~clk;

  function automatic logic [3:0] table_pat(int md, int i);
    logic [3:0] wv[4] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000};
    logic [3:0] fl[4] = '{4'b0011, 4'b0110, 4'b1100, 4'b1001};
    logic [3:0] hf[8] = '{4'b0001, 4'b0011, 4'b0010, 4'b0110,
                          4'b0100, 4'b1100, 4'b1000, 4'b1001};
    if (md == 1) return fl[i % 4];
    if (md == 2) return hf[i % 8];
    return wv[i % 4];
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: phase_out=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of inputs, predict output after next edge
  task automatic cyc(string tag, bit t, bit en, bit d, bit s, int md,
                     int per, int dt);
    int len;
    logic [3:0] e;
    @(negedge clk);
    tick = t; step_en = en; dir = d; stop = s; mode = md[1:0];
    pwm_period = per[7:0]; pwm_duty = dt[7:0];
    len = (m_mode == 2) ? 8 : 4;
    if (md != m_mode) m_idx = 0;
    else if (t && en && !s) m_idx = d ? (m_idx + len - 1) % len : (m_idx + 1) % len;
    m_mode = md;
    if (!s) m_cnt = 0;
    else if (m_cnt >= per) m_cnt = 0;
    else m_cnt = m_cnt + 1;
    e = table_pat(m_mode, m_idx);
    if (s && !(m_cnt < dt)) e = 4'b0000;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) check(tag_q.pop_front(), phase_out, exp_q.pop_front());
    end
  end

  initial begin
    #1;
    check("R1 in reset", phase_out, 4'b0001);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1 after release", phase_out, 4'b0001);
    // R2 wave forward, wraps after D
    for (int i = 0; i < 5; i++) cyc("R2 wave fwd", 1, 1, 0, 0, 0, 0, 0);
    // R6 no step without both tick and enable
    cyc("R6 tick only", 1, 0, 0, 0, 0, 0, 0);
    cyc("R6 enable only", 0, 1, 0, 0, 0, 0, 0);
    cyc("R6 idle", 0, 0, 0, 0, 0, 0, 0);
    // R5 reverse in wave, crossing wrap
    for (int i = 0; i < 4; i++) cyc("R5 wave rev", 1, 1, 1, 0, 0, 0, 0);
    // R7 switch to full step: resync to state 0 even with a step requested
    cyc("R7 resync full", 1, 1, 0, 0, 1, 0, 0);
    for (int i = 0; i < 5; i++) cyc("R3 full fwd", 1, 1, 0, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R5 full rev", 1, 1, 1, 0, 1, 0, 0);
    // R7 switch to half step
    cyc("R7 resync half", 0, 0, 0, 0, 2, 0, 0);
    for (int i = 0; i < 9; i++) cyc("R4 half fwd", 1, 1, 0, 0, 2, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R5 half rev", 1, 1, 1, 0, 2, 0, 0);
    cyc("R2 code 3 as wave", 0, 0, 0, 0, 3, 0, 0);
    cyc("R2 code 3 step", 1, 1, 0, 0, 3, 0, 0);
    // back to half, move to an odd (two-phase) state
    cyc("R7 resync half", 0, 0, 0, 0, 2, 0, 0);
    cyc("R4 half step", 1, 1, 0, 0, 2, 0, 0);
    // R8/R9 hold with period 3 duty 2, steps requested
    for (int i = 0; i < 10; i++) cyc("R8 R9 hold pwm", 1, 1, 0, 1, 2, 3, 2);
    // R10 duty 0 gives all phases off
    for (int i = 0; i < 4; i++) cyc("R10 duty zero", 1, 1, 0, 1, 2, 3, 0);
    // R9 period 0: counter stays at 0, duty 1 keeps gate on
    for (int i = 0; i < 3; i++) cyc("R9 period zero", 0, 0, 0, 1, 2, 0, 1);
    // R9 duty above period: always on
    for (int i = 0; i < 3; i++) cyc("R9 duty over period", 0, 0, 0, 1, 2, 2, 9);
    // R11 release stop, then step onward
    cyc("R11 release", 0, 0, 0, 0, 2, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R11 resume", 1, 1, 0, 0, 2, 0, 0);
    // R8 mode change during hold still resyncs, output chopped
    for (int i = 0; i < 4; i++) cyc("R8 R7 hold resync", 1, 1, 0, 1, 1, 1, 1);
    cyc("R11 release full", 0, 0, 0, 0, 1, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule